// File: doc/BRIEF.md
# FSK Receive Character Framer

This block sits behind an FSK demodulator and turns its recovered binary stream into something a microcontroller can use. It exposes two registers on a small special-function-register port: a control register and a receive buffer. The data path runs only when the control register enables the detector and selects FSK operation. Otherwise the framer idles and the interrupt stays low.

There are two operating styles. In raw-level style, the synchronised demodulator level is copied every clock into the most significant bit of the buffer, and firmware polls it. In character style, a retiming state machine finds asynchronous characters at the line rate. Each character is a low start bit, eight data bits sent least significant first, and a high stop bit. Each valid character is latched into the buffer and raises a pending flag, which drives the interrupt output. Reading the buffer clears the flag. A character that has not been read is silently replaced when the next one arrives.

Timing comes from a baud counter derived from the system clock frequency and the line rate. The counter restarts on each start-bit falling edge, so every bit is sampled near its centre.

Top module: `fsk_char_framer`

## Requirements
- R1: After reset the control register (address 0xE9) reads 0x00, the buffer (address 0xEA) reads 0x00 and `irq` is low.
- R2: Control bit 7 is the enable, bit 6 selects FSK (1) versus tone (0), and bit 3 selects raw-level style (1) versus character style (0). Bits 5, 4, 2 and 1 read as 0. Bit 0 reads as the pending flag and ignores writes.
- R3: In character style, a frame made of a 0 start bit, eight data bits least significant first and a 1 stop bit loads those eight bits into the buffer.
- R4: Completion of a valid character sets the pending flag (control bit 0) and drives `irq` high.
- R5: A read of the buffer address clears the pending flag and `irq` on the following clock.
- R6: If a second valid character completes before the buffer is read, the buffer holds the second character and `irq` stays high.
- R7: A continuous alternating 0/1 line pattern beginning with a 0 frames as repeated 0x55 characters.
- R8: A frame whose stop bit samples as 0 is discarded. The buffer and `irq` are unchanged.
- R9: A start bit that is high again at its mid-bit re-sample is rejected. No character is produced.
- R10: When the enable is 0 or tone mode is selected, no characters are framed, the buffer is unchanged and `irq` is low.
- R11: In raw-level style, buffer bit 7 follows the line level three clocks after it changes, and `irq` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Demodulated serial line level (idle high) |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe; a buffer read clears the pending flag |
| sfr_rdata | output | 8 | Read data, valid the clock after `sfr_rd` |
| irq | output | 1 | Interrupt, high while a received character is pending |

## Verification
Two cases are hard to reach: a start bit that collapses before its centre, and a stop bit that is low. Neither occurs in well-formed traffic. The bench produces them by driving the line cycle by cycle with a glitch shorter than half a bit, and by framing a character with a forced-low stop bit. In both cases it checks that the earlier buffer contents survive. An unbroken alternating stream is also sent, so that each stop bit is followed at once by the next start bit, with no idle gap between characters.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } frm_state_t;

  localparam int CB_ENABLE = 7;
  localparam int CB_FSK    = 6;
  localparam int CB_RAW    = 3;
  localparam int CB_PEND   = 0;
endpackage

// File: rtl/fsk_rx_sync.sv
module fsk_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fsk_baud_timer.sv
module fsk_baud_timer #(
  parameter int CYC_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic half_tick,
  output logic bit_tick
);
  localparam int HALF = CYC_PER_BIT / 2;
  localparam int CW   = $clog2(CYC_PER_BIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt_q <= '0;
    else if (run) begin
      if (cnt_q == CW'(CYC_PER_BIT - 1)) cnt_q <= '0;
      else                               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign half_tick = run && (cnt_q == CW'(HALF - 1));
  assign bit_tick  = run && (cnt_q == CW'(CYC_PER_BIT - 1));
endmodule

// File: rtl/fsk_frame_fsm.sv
module fsk_frame_fsm
  import fsk_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 rx,
  input  logic                 half_tick,
  input  logic                 bit_tick,
  output logic                 restart,
  output logic                 run,
  output logic                 done,
  output logic                 ferr,
  output logic [DATA_BITS-1:0] data
);
  localparam int IW = $clog2(DATA_BITS);

  frm_state_t           state_q;
  logic                 rx_prev_q;
  logic [IW-1:0]        idx_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 fall;

  assign fall    = rx_prev_q && !rx;
  assign run     = (state_q != ST_IDLE);
  assign restart = (state_q == ST_IDLE && active && fall) ||
                   (state_q == ST_START && half_tick && !rx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rx_prev_q <= 1'b1;
      idx_q     <= '0;
      shift_q   <= '0;
      done      <= 1'b0;
      ferr      <= 1'b0;
      data      <= '0;
    end else begin
      rx_prev_q <= rx;
      done      <= 1'b0;
      ferr      <= 1'b0;
      if (!active) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (fall) state_q <= ST_START;
          ST_START: if (half_tick) begin
            if (!rx) begin
              state_q <= ST_DATA;
              idx_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_DATA: if (bit_tick) begin
            shift_q <= {rx, shift_q[DATA_BITS-1:1]};
            if (idx_q == IW'(DATA_BITS - 1)) state_q <= ST_STOP;
            else                             idx_q   <= idx_q + 1'b1;
          end
          ST_STOP: if (bit_tick) begin
            state_q <= ST_IDLE;
            if (rx) begin
              done <= 1'b1;
              data <= shift_q;
            end else begin
              ferr <= 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fsk_sfr_regs.sv
module fsk_sfr_regs
  import fsk_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'hE9,
  parameter logic [AW-1:0] BUF_ADDR  = 8'hEA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          wr,
  input  logic          rd,
  input  logic          rx,
  input  logic          done,
  input  logic [7:0]    data,
  output logic          byte_act,
  output logic          bit_act,
  output logic [7:0]    buf_q,
  output logic [7:0]    rdata,
  output logic          pend_q
);
  logic en_q, fsk_q, raw_q;
  logic [7:0] ctrl_view;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[5:4], wdata[2:0]};
  assign byte_act = en_q && fsk_q && !raw_q;
  assign bit_act  = en_q && fsk_q && raw_q;

  always_comb begin
    ctrl_view            = '0;
    ctrl_view[CB_ENABLE] = en_q;
    ctrl_view[CB_FSK]    = fsk_q;
    ctrl_view[CB_RAW]    = raw_q;
    ctrl_view[CB_PEND]   = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      fsk_q <= 1'b0;
      raw_q <= 1'b0;
    end else if (wr && addr == CTRL_ADDR) begin
      en_q  <= wdata[CB_ENABLE];
      fsk_q <= wdata[CB_FSK];
      raw_q <= wdata[CB_RAW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 buf_q    <= '0;
    else if (bit_act)        buf_q[7] <= rx;
    else if (byte_act && done) buf_q  <= data;
  end

  always_ff @(posedge clk) begin
    if (rst)                       pend_q <= 1'b0;
    else if (!byte_act)            pend_q <= 1'b0;
    else if (done)                 pend_q <= 1'b1;
    else if (rd && addr == BUF_ADDR) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) begin
      if (addr == CTRL_ADDR)     rdata <= ctrl_view;
      else if (addr == BUF_ADDR) rdata <= buf_q;
      else                       rdata <= '0;
    end
  end
endmodule

// File: rtl/fsk_char_framer.sv
module fsk_char_framer #(
  parameter int          CLK_HZ      = 50_000_000,
  parameter int          BAUD        = 1200,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CTRL_ADDR   = 8'hE9,
  parameter logic [7:0]  BUF_ADDR    = 8'hEA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_bit,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_wr,
  input  logic       sfr_rd,
  output logic [7:0] sfr_rdata,
  output logic       irq
);
  localparam int CYC_PER_BIT = CLK_HZ / BAUD;

  logic       rx_s;
  logic       half_tick, bit_tick, restart, run;
  logic       frame_done, frame_err;
  logic [7:0] frame_data;
  logic       byte_act, bit_act;
  logic [7:0] buf_q;

  fsk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_bit), .dout(rx_s)
  );

  fsk_baud_timer #(.CYC_PER_BIT(CYC_PER_BIT)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .run(run),
    .half_tick(half_tick), .bit_tick(bit_tick)
  );

  fsk_frame_fsm #(.DATA_BITS(8)) u_fsm (
    .clk(clk), .rst(rst), .active(byte_act), .rx(rx_s),
    .half_tick(half_tick), .bit_tick(bit_tick),
    .restart(restart), .run(run), .done(frame_done),
    .ferr(frame_err), .data(frame_data)
  );

  fsk_sfr_regs #(.AW(8), .CTRL_ADDR(CTRL_ADDR), .BUF_ADDR(BUF_ADDR)) u_regs (
    .clk(clk), .rst(rst), .addr(sfr_addr), .wdata(sfr_wdata),
    .wr(sfr_wr), .rd(sfr_rd), .rx(rx_s), .done(frame_done),
    .data(frame_data), .byte_act(byte_act), .bit_act(bit_act),
    .buf_q(buf_q), .rdata(sfr_rdata), .pend_q(irq)
  );
endmodule

// File: rtl/fsk_framer_chk.sv
module fsk_framer_chk #(
  parameter logic [7:0] BUF_ADDR = 8'hEA
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] sfr_addr,
  input logic       sfr_rd,
  input logic       sfr_wr,
  input logic       irq,
  input logic       frame_done,
  input logic       frame_err,
  input logic       byte_act,
  input logic       bit_act,
  input logic [7:0] buf_q
);
  // R4
  done_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done && byte_act) |=> irq);

  // R5
  read_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd && sfr_addr == BUF_ADDR && !frame_done) |=> !irq);

  // R8
  ferr_keeps_buf_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_err && byte_act && !sfr_wr) |=> $stable(buf_q));

  // R10
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (!byte_act && !bit_act) |=> !irq);

  // R11
  raw_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    bit_act |=> !irq);
endmodule

bind fsk_char_framer fsk_framer_chk #(.BUF_ADDR(BUF_ADDR)) u_chk (
  .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
  .sfr_wr(sfr_wr), .irq(irq), .frame_done(frame_done),
  .frame_err(frame_err), .byte_act(byte_act), .bit_act(bit_act),
  .buf_q(buf_q)
);

// File: tb/sim_fsk_char_framer.sv
module sim_fsk_char_framer;
  localparam int CLK_HZ = 19200;
  localparam int BAUD   = 1200;
  localparam int CYC    = CLK_HZ / BAUD;
  localparam logic [7:0] A_CTRL = 8'hE9;
  localparam logic [7:0] A_BUF  = 8'hEA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit = 1'b1;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
  logic sfr_wr = 1'b0, sfr_rd = 1'b0, irq;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fsk_char_framer #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u0 (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_rdata(sfr_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_rd = 1'b1;
    @(negedge clk);
    sfr_rd = 1'b0;
    d = sfr_rdata;
  endtask

  task automatic line_bit(input logic b);
    rx_bit = b;
    repeat (CYC) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] v, input logic stop_v);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(v[i]);
    line_bit(stop_v);
    line_bit(1'b1);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    sfr_read(A_CTRL, rd); check("R1 ctrl", rd, 8'h00);
    sfr_read(A_BUF, rd);  check("R1 buf", rd, 8'h00);

    // R2 writable mask
    sfr_write(A_CTRL, 8'hFF);
    sfr_read(A_CTRL, rd); check("R2 ctrl mask", rd, 8'hC8);

    // R3/R4/R5 sweep of every byte value
    sfr_write(A_CTRL, 8'hC0);
    for (int v = 0; v < 256; v++) begin
      send_char(8'(v), 1'b1);
      check("R4 irq set", {7'b0, irq}, 8'h01);
      sfr_read(A_CTRL, rd); check("R4 pend bit", rd, 8'hC1);
      sfr_read(A_BUF, rd);  check("R3 data", rd, 8'(v));
      check("R5 irq clear", {7'b0, irq}, 8'h00);
    end

    // R6 overwrite of unread byte
    send_char(8'h12, 1'b1);
    send_char(8'h34, 1'b1);
    check("R6 irq held", {7'b0, irq}, 8'h01);
    sfr_read(A_BUF, rd); check("R6 latest", rd, 8'h34);

    // R7 alternating stream
    @(negedge clk);
    for (int k = 0; k < 30; k++) line_bit(k[0]);
    line_bit(1'b1);
    check("R7 irq", {7'b0, irq}, 8'h01);
    sfr_read(A_BUF, rd); check("R7 byte", rd, 8'h55);

    // R9 short glitch rejected
    rx_bit = 1'b0;
    repeat (CYC / 4) @(negedge clk);
    rx_bit = 1'b1;
    repeat (12 * CYC) @(negedge clk);
    check("R9 no irq", {7'b0, irq}, 8'h00);
    sfr_read(A_BUF, rd); check("R9 buf kept", rd, 8'h55);
    send_char(8'hA5, 1'b1);
    sfr_read(A_BUF, rd); check("R9 recovers", rd, 8'hA5);

    // R8 framing error
    send_char(8'h3C, 1'b0);
    check("R8 no irq", {7'b0, irq}, 8'h00);
    sfr_read(A_BUF, rd); check("R8 buf kept", rd, 8'hA5);

    // R10 tone mode, then disabled
    sfr_write(A_CTRL, 8'h80);
    send_char(8'h77, 1'b1);
    check("R10 tone irq", {7'b0, irq}, 8'h00);
    sfr_write(A_CTRL, 8'h40);
    send_char(8'h66, 1'b1);
    check("R10 off irq", {7'b0, irq}, 8'h00);
    sfr_write(A_CTRL, 8'hC0);
    sfr_read(A_BUF, rd); check("R10 buf kept", rd, 8'hA5);

    // R11 raw-level style
    sfr_write(A_CTRL, 8'hC8);
    rx_bit = 1'b0;
    repeat (4) @(negedge clk);
    sfr_read(A_BUF, rd); check("R11 bit7 low", {7'b0, rd[7]}, 8'h00);
    rx_bit = 1'b1;
    repeat (4) @(negedge clk);
    sfr_read(A_BUF, rd); check("R11 bit7 high", {7'b0, rd[7]}, 8'h01);
    send_char(8'h0F, 1'b1);
    check("R11 no irq", {7'b0, irq}, 8'h00);
    sfr_read(A_CTRL, rd); check("R11 pend low", rd, 8'hC8);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule